// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog that software must keep feeding. A counter advances on each cycle where a slow clock enable is high. If the counter reaches the end of its period, the block pulses an internal reset request. Software restarts the counter by writing one fixed key byte to the key register. The block treats any other byte, or any single-bit read-modify-write access to that register, as a fault, and raises the reset request at once. Reading the key register returns a fixed signature, not the key.

A mode register holds a 3-bit field that picks one of eight power-of-two periods. A strap input is captured only while system reset is active. It decides whether the counter may pause in the HALT and STOP low-power states, or must keep running through them. When pausing is allowed, the count is frozen during the low-power state. Counting resumes from the same value, with the same period selection, after the state is left.

Top module: `key_watchdog`

## Requirements
- R1: After synchronous reset, `rst_req` is low, the counter is zero, and a read of the mode register (`addr`=0) returns 0x07 (the longest period).
- R2: A whole-byte write (`bit_op`=0) of 0xAC to the key register (`addr`=1) raises no request and clears the counter. A full period of ticks is then needed before overflow.
- R3: A whole-byte write to the key register of any value other than 0xAC makes `rst_req` high in the cycle after the write.
- R4: A write to the key register with `bit_op`=1 makes `rst_req` high in the cycle after the write, even when the data is 0xAC.
- R5: A read of the key register returns 0x9A.
- R6: A whole-byte write to the mode register stores `wdata[2:0]` as the period select, and the register reads back as {5'b0, select}. A write with `bit_op`=1 leaves the register unchanged.
- R7: With select S, `rst_req` pulses in the cycle after the 2^(BASE_EXP+S)-th tick since the last clear. The counter then restarts from zero.
- R8: The counter advances only on cycles where `lsclk_en` is high.
- R9: When the captured strap is 0, ticks are counted during HALT and STOP, and an overflow in STOP raises `rst_req`.
- R10: When the captured strap is 1, no tick is counted while `halt_mode` or `stop_mode` is high. The count is kept and counting resumes from it afterwards.
- R11: The strap `clk_stoppable` is sampled only while `rst` is high. Later changes on the input have no effect.
- R12: `rst_req` is a single-cycle pulse for each fault or overflow event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lsclk_en | input | 1 | Slow clock enable, one tick per high cycle |
| clk_stoppable | input | 1 | Strap, 1 = counter may pause in HALT/STOP |
| halt_mode | input | 1 | CPU is in HALT |
| stop_mode | input | 1 | CPU is in STOP |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| bit_op | input | 1 | Access is a single-bit read-modify-write |
| addr | input | 1 | 0 = mode register, 1 = key register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| rst_req | output | 1 | Internal reset request pulse |

## Verification
The overflow timing is tried with a steady tick enable and with a random on/off tick pattern at each period select. The random pattern shows whether the counter follows the number of ticks rather than the number of cycles. Key writes with random bytes separate the single accepted value from all others. A bit-level write carrying the correct key shows that the access type, and not only the data, is checked. Low-power runs under both strap values show whether the count is frozen or keeps running, and a strap change after reset shows that only the value captured at reset matters.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam logic [7:0] KEY_BYTE   = 8'hAC;
  localparam logic [7:0] SIGNATURE  = 8'h9A;
  localparam logic       ADDR_MODE  = 1'b0;
  localparam logic       ADDR_KEY   = 1'b1;

  // true when a key-register write is a legal restart
  function automatic logic key_is_valid(input logic bit_access, input logic [7:0] data);
    return (!bit_access) && (data == KEY_BYTE);
  endfunction
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
  import kwd_pkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int DEF_SEL = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             bit_op,
  input  logic             addr,
  input  logic [7:0]       wdata,
  output logic [SEL_W-1:0] mode_sel,
  output logic             key_ok,
  output logic             key_bad,
  output logic [7:0]       rdata
);
  logic key_wr, mode_wr;

  assign key_wr  = wr_en && (addr == ADDR_KEY);
  assign mode_wr = wr_en && (addr == ADDR_MODE) && !bit_op;
  assign key_ok  = key_wr && key_is_valid(bit_op, wdata);
  assign key_bad = key_wr && !key_is_valid(bit_op, wdata);

  always_ff @(posedge clk) begin
    if (rst)          mode_sel <= SEL_W'(DEF_SEL);
    else if (mode_wr) mode_sel <= wdata[SEL_W-1:0];
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      if (addr == ADDR_KEY) rdata = SIGNATURE;
      else                  rdata = 8'(mode_sel);
    end
  end
endmodule

// File: rtl/kwd_gate.sv
module kwd_gate (
  input  logic clk,
  input  logic rst,
  input  logic strap_in,
  input  logic lsclk_en,
  input  logic halt_mode,
  input  logic stop_mode,
  output logic strap_q,
  output logic tick
);
  always_ff @(posedge clk) begin
    if (rst) strap_q <= strap_in;
  end

  assign tick = lsclk_en && !(strap_q && (halt_mode || stop_mode));
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int BASE_EXP = 10,
  parameter int SEL_W    = 3,
  localparam int NSEL    = 1 << SEL_W,
  localparam int CNT_W   = BASE_EXP + NSEL - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             clear,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  // last count value before overflow: 2^(BASE_EXP+sel) - 1
  function automatic logic [CNT_W-1:0] last_count(input logic [SEL_W-1:0] s);
    return {CNT_W{1'b1}} >> (NSEL - 1 - int'(s));
  endfunction

  assign ovf = tick && !clear && (count >= last_count(sel));

  always_ff @(posedge clk) begin
    if (rst)               count <= '0;
    else if (clear || ovf) count <= '0;
    else if (tick)         count <= count + 1'b1;
  end
endmodule

// File: rtl/key_watchdog.sv
module key_watchdog #(
  parameter int BASE_EXP = 10,
  parameter int SEL_W    = 3,
  localparam int NSEL    = 1 << SEL_W,
  localparam int CNT_W   = BASE_EXP + NSEL - 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lsclk_en,
  input  logic       clk_stoppable,
  input  logic       halt_mode,
  input  logic       stop_mode,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       bit_op,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       rst_req
);
  logic [SEL_W-1:0] mode_sel;
  logic             key_ok, key_bad, strap_q, tick, ovf;
  logic [CNT_W-1:0] count;

  kwd_regs #(.SEL_W(SEL_W), .DEF_SEL(NSEL-1)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .bit_op(bit_op),
    .addr(addr), .wdata(wdata), .mode_sel(mode_sel), .key_ok(key_ok),
    .key_bad(key_bad), .rdata(rdata)
  );

  kwd_gate u_gate (
    .clk(clk), .rst(rst), .strap_in(clk_stoppable), .lsclk_en(lsclk_en),
    .halt_mode(halt_mode), .stop_mode(stop_mode), .strap_q(strap_q), .tick(tick)
  );

  kwd_counter #(.BASE_EXP(BASE_EXP), .SEL_W(SEL_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .clear(key_ok), .sel(mode_sel),
    .count(count), .ovf(ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) rst_req <= 1'b0;
    else     rst_req <= ovf || key_bad;
  end
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker #(
  parameter int SEL_W = 3,
  parameter int CNT_W = 17
) (
  input logic             clk,
  input logic             rst,
  input logic             lsclk_en,
  input logic             halt_mode,
  input logic             stop_mode,
  input logic             wr_en,
  input logic             rd_en,
  input logic             bit_op,
  input logic             addr,
  input logic [7:0]       wdata,
  input logic [7:0]       rdata,
  input logic             rst_req,
  input logic [SEL_W-1:0] mode_sel,
  input logic             key_ok,
  input logic             key_bad,
  input logic             strap_q,
  input logic             tick,
  input logic             ovf,
  input logic [CNT_W-1:0] count
);
  a_r2_key_clears: assert property (@(posedge clk) disable iff (rst)
    key_ok |=> (count == '0));
  a_r3_bad_key: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr && !bit_op && wdata != 8'hAC) |=> rst_req);
  a_r4_bit_access: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr && bit_op) |=> rst_req);
  a_r5_signature: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr) |-> (rdata == 8'h9A));
  a_r6_mode_bitop: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !addr && bit_op) |=> $stable(mode_sel));
  a_r7_overflow: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (rst_req && count == '0));
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !key_ok) |=> $stable(count));
  a_r9_runs: assert property (@(posedge clk) disable iff (rst)
    (!strap_q && lsclk_en) |-> tick);
  a_r10_freeze: assert property (@(posedge clk) disable iff (rst)
    (strap_q && (halt_mode || stop_mode)) |-> !tick);
  a_r11_strap: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(strap_q));
  a_r12_cause: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(ovf || key_bad));
endmodule

bind key_watchdog kwd_checker #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .lsclk_en(lsclk_en), .halt_mode(halt_mode),
  .stop_mode(stop_mode), .wr_en(wr_en), .rd_en(rd_en), .bit_op(bit_op),
  .addr(addr), .wdata(wdata), .rdata(rdata), .rst_req(rst_req),
  .mode_sel(mode_sel), .key_ok(key_ok), .key_bad(key_bad), .strap_q(strap_q),
  .tick(tick), .ovf(ovf), .count(count)
);

// File: tb/key_watchdog_test.sv
module key_watchdog_test;
  localparam int BASE = 4;

  logic clk = 1'b0;
  logic rst = 1'b1, lsclk_en = 1'b0, strap = 1'b0, halt_m = 1'b0, stop_m = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, bit_op = 1'b0, addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic rst_req;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  key_watchdog #(.BASE_EXP(BASE), .SEL_W(3)) uut (
    .clk(clk), .rst(rst), .lsclk_en(lsclk_en), .clk_stoppable(strap),
    .halt_mode(halt_m), .stop_mode(stop_m), .wr_en(wr_en), .rd_en(rd_en),
    .bit_op(bit_op), .addr(addr), .wdata(wdata), .rdata(rdata), .rst_req(rst_req)
  );

  function automatic int period(input int sel);
    return 1 << (BASE + sel);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_req(input string req, input logic exp);
    check(rst_req === exp, req, int'(rst_req), int'(exp));
  endtask

  task automatic do_reset(input logic s);
    strap = s; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d, input logic b);
    wr_en = 1'b1; addr = a; wdata = d; bit_op = b;
    @(negedge clk);
    wr_en = 1'b0; bit_op = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    rd_en = 1'b1; addr = a;
    #1 v = rdata;
    rd_en = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    lsclk_en = 1'b1;
    repeat (n) @(negedge clk);
    lsclk_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int seed;
    seed = $urandom(32'd2024);

    // R1 reset state
    do_reset(1'b0);
    check_req("R1", 1'b0);
    rd(1'b0, v); check(v == 8'h07, "R1", v, 8'h07);
    // R5 signature
    rd(1'b1, v); check(v == 8'h9A, "R5", v, 8'h9A);

    // R6 mode write and ignored bit access
    wr(1'b0, 8'h02, 1'b0);
    rd(1'b0, v); check(v == 8'h02, "R6", v, 8'h02);
    wr(1'b0, 8'h05, 1'b1);
    rd(1'b0, v); check(v == 8'h02, "R6", v, 8'h02);
    wr(1'b0, 8'hFA, 1'b0);
    rd(1'b0, v); check(v == 8'h02, "R6", v, 8'h02);

    // R2 / R7 steady overflow at select 2
    wr(1'b1, 8'hAC, 1'b0); check_req("R2", 1'b0);
    run_ticks(period(2) - 1); check_req("R7", 1'b0);
    run_ticks(1); check_req("R7", 1'b1);
    @(negedge clk); check_req("R12", 1'b0);
    run_ticks(period(2) - 1); check_req("R7", 1'b0);
    run_ticks(1); check_req("R7", 1'b1);
    @(negedge clk);

    // R2 restart mid-period
    wr(1'b1, 8'hAC, 1'b0);
    run_ticks(50);
    wr(1'b1, 8'hAC, 1'b0);
    run_ticks(period(2) - 1); check_req("R2", 1'b0);
    run_ticks(1); check_req("R2", 1'b1);
    @(negedge clk);

    // R8 no ticks, no progress
    wr(1'b1, 8'hAC, 1'b0);
    repeat (500) @(negedge clk);
    check_req("R8", 1'b0);
    run_ticks(period(2) - 1); check_req("R8", 1'b0);
    run_ticks(1); check_req("R8", 1'b1);
    @(negedge clk);

    // R3 wrong key, R4 bit access with right key
    wr(1'b1, 8'h55, 1'b0); check_req("R3", 1'b1);
    @(negedge clk); check_req("R12", 1'b0);
    wr(1'b1, 8'hAC, 1'b1); check_req("R4", 1'b1);
    @(negedge clk); check_req("R4", 1'b0);
    rd(1'b1, v); check(v == 8'h9A, "R5", v, 8'h9A);

    // R9 strap 0: runs through STOP and HALT
    do_reset(1'b0);
    wr(1'b0, 8'h00, 1'b0);
    wr(1'b1, 8'hAC, 1'b0);
    stop_m = 1'b1;
    run_ticks(period(0) - 1); check_req("R9", 1'b0);
    run_ticks(1); check_req("R9", 1'b1);
    stop_m = 1'b0; @(negedge clk);
    wr(1'b1, 8'hAC, 1'b0);
    halt_m = 1'b1;
    run_ticks(period(0)); check_req("R9", 1'b1);
    halt_m = 1'b0; @(negedge clk);

    // R10 strap 1: frozen in HALT and STOP
    do_reset(1'b1);
    wr(1'b0, 8'h03, 1'b0);
    wr(1'b1, 8'hAC, 1'b0);
    run_ticks(100);
    halt_m = 1'b1; run_ticks(500); halt_m = 1'b0;
    check_req("R10", 1'b0);
    stop_m = 1'b1; run_ticks(300); stop_m = 1'b0;
    check_req("R10", 1'b0);
    rd(1'b0, v); check(v == 8'h03, "R10", v, 8'h03);
    run_ticks(period(3) - 101); check_req("R10", 1'b0);
    run_ticks(1); check_req("R10", 1'b1);
    @(negedge clk);

    // R11 strap only captured during reset
    do_reset(1'b0);
    strap = 1'b1;
    wr(1'b0, 8'h00, 1'b0);
    wr(1'b1, 8'hAC, 1'b0);
    stop_m = 1'b1; run_ticks(period(0)); stop_m = 1'b0;
    check_req("R11", 1'b1);
    do_reset(1'b1);
    strap = 1'b0;
    wr(1'b0, 8'h00, 1'b0);
    wr(1'b1, 8'hAC, 1'b0);
    stop_m = 1'b1; run_ticks(200); stop_m = 1'b0;
    check_req("R11", 1'b0);

    // random tick patterns and random key bytes
    do_reset(1'b0);
    for (int it = 0; it < 12; it++) begin
      int sel, ticks, lim;
      logic [7:0] d;
      sel = int'($urandom % 8);
      lim = period(sel);
      wr(1'b0, 8'(sel), 1'b0);
      wr(1'b1, 8'hAC, 1'b0);
      ticks = 0;
      while (ticks < lim) begin
        logic en;
        en = 1'($urandom % 2);
        lsclk_en = en;
        @(negedge clk);
        if (en) ticks++;
        check_req("R7", (ticks == lim) ? 1'b1 : 1'b0);
      end
      lsclk_en = 1'b0;
      @(negedge clk);
      d = (it % 3 == 0) ? 8'hAC : 8'($urandom);
      wr(1'b1, d, 1'b0);
      check_req("R3", (d != 8'hAC) ? 1'b1 : 1'b0);
      @(negedge clk);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule